// File: doc/BRIEF.md
# Byte-Stream Boot Word Loader

This block brings up a processor whose program RAM is 24 bits wide while the program image sits in a memory that is only one byte wide. It waits in an idle state after reset. When it sees a start pulse, it reads consecutive bytes from the external memory, beginning at a fixed base address. Every three bytes are packed into one word, and each word is written into program RAM at the next address, starting from address zero.

Bytes arrive least significant first. Each byte enters the top of a shift register, and the register shifts right by one byte, so after three bytes the word is complete and in the right order. Every external read holds the address steady for a configurable number of wait cycles before the byte is sampled. This lets slow memories be used without a handshake.

Once the configured number of words has been written, the loader stops all traffic. It then raises a run output that lets the processor begin fetching at address zero. That is where the first loaded word was placed.

Top module: `boot_word_loader`

## Requirements
- R1: After reset, `ext_rd`, `ram_we`, `busy` and `cpu_run` are low, `ext_addr` equals `SRC_BASE` (default 0x8000), and `ram_addr` is 0.
- R2: A start pulse while idle begins the copy, and `busy` is high in the next cycle. A start pulse during the copy or after it has finished has no effect on addresses, data or outputs.
- R3: Each external byte read keeps `ext_rd` high and `ext_addr` constant for exactly `WAIT_CYCLES`+1 cycles. The byte is sampled at the clock edge that ends the last of those cycles.
- R4: External byte addresses run consecutively upward from `SRC_BASE`, one per byte, with no address skipped or repeated.
- R5: Each written word is {third byte, second byte, first byte}: the first byte read lands in bits 7:0, the second in bits 15:8 and the third in bits 23:16.
- R6: Written RAM addresses start at 0 and increase by one for each word.
- R7: `ram_we` is high for exactly one cycle per completed word. It is never high for a partly assembled word and never high on two adjacent cycles.
- R8: `cpu_run` rises in the cycle right after the final RAM write and stays high. From then on, `ext_rd` and `ram_we` stay low.
- R9: The number of words copied equals the parameter `WORD_COUNT` (default 1000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; acted on only while idle |
| ext_rd | output | 1 | External byte read strobe |
| ext_addr | output | EXT_AW | External byte address |
| ext_data | input | 8 | External byte data |
| ram_we | output | 1 | Program RAM write strobe |
| ram_addr | output | RAM_AW | Program RAM word address |
| ram_data | output | 24 | Program RAM write data |
| busy | output | 1 | Copy in progress |
| cpu_run | output | 1 | Processor released to run from address 0 |

## Verification
The RAM write of a finished word happens in the same cycle as the first read cycle of the next word's first byte. So the packing register is emptied and refilled while the fetch side carries on. The bench provokes this on every word boundary across a long run of pseudo-random image bytes. For each pulse it compares the written word and its address against values computed from the image function. It also checks that the byte address sequence and the hold length per byte stay exact through those overlapping cycles. A second overlap, a start pulse landing in the middle of a copy, is injected at a random point. It is judged by the undisturbed word and address sequence.

// File: rtl/boot_ld_pkg.sv
package boot_ld_pkg;
   typedef enum logic [1:0] {
      LD_IDLE  = 2'd0,
      LD_COPY  = 2'd1,
      LD_FLUSH = 2'd2,
      LD_RUN   = 2'd3
   } ld_state_e;
endpackage

// File: rtl/ld_byte_fetch.sv
module ld_byte_fetch #(
   parameter int             EXT_AW      = 16,
   parameter int             BYTE_W      = 8,
   parameter int             WAIT_CYCLES = 2,
   parameter logic [EXT_AW-1:0] SRC_BASE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [BYTE_W-1:0] ext_data,
   output logic              ext_rd,
   output logic [EXT_AW-1:0] ext_addr,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_data
);
   localparam logic [EXT_AW-1:0] ADDR_ONE = EXT_AW'(1);

   logic [EXT_AW-1:0] addr_q;

   assign ext_rd    = en;
   assign ext_addr  = addr_q;
   assign byte_data = ext_data;

   generate
      if (WAIT_CYCLES == 0) begin : g_nowait
         assign byte_valid = en;
      end else begin : g_wait
         localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);
         localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_CYCLES);
         logic [WAIT_W-1:0] wait_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wait_q <= '0;
            end else if (!en || wait_q == WAIT_LAST) begin
               wait_q <= '0;
            end else begin
               wait_q <= wait_q + WAIT_W'(1);
            end
         end

         assign byte_valid = en && (wait_q == WAIT_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= SRC_BASE;
      end else if (byte_valid) begin
         addr_q <= addr_q + ADDR_ONE;
      end
   end

   // address must hold while a read is still waiting
   assert_hold_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_rd && !byte_valid) |=> $stable(ext_addr));

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> (ext_addr == $past(ext_addr) + ADDR_ONE));
endmodule

// File: rtl/ld_word_pack.sv
module ld_word_pack #(
   parameter int BYTE_W         = 8,
   parameter int BYTES_PER_WORD = 3,
   localparam int WORD_W        = BYTE_W * BYTES_PER_WORD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   output logic              last_byte,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data
);
   logic [WORD_W-1:0] shift_q;
   logic              wv_q;

   generate
      if (BYTES_PER_WORD == 1) begin : g_single
         assign last_byte = byte_valid;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) shift_q <= '0;
            else if (byte_valid) shift_q <= byte_data;
         end
      end else begin : g_multi
         localparam int IDX_W = $clog2(BYTES_PER_WORD);
         localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTES_PER_WORD - 1);
         logic [IDX_W-1:0] idx_q;

         assign last_byte = byte_valid && (idx_q == IDX_LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idx_q   <= '0;
               shift_q <= '0;
            end else if (byte_valid) begin
               shift_q <= {byte_data, shift_q[WORD_W-1:BYTE_W]};
               idx_q   <= (idx_q == IDX_LAST) ? '0 : idx_q + IDX_W'(1);
            end
         end

         // a full word takes several bytes, so strobes cannot touch
         assert_we_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wv_q |=> !wv_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wv_q <= 1'b0;
      else        wv_q <= last_byte;
   end

   assign word_valid = wv_q;
   assign word_data  = shift_q;
endmodule

// File: rtl/ld_word_count.sv
module ld_word_count #(
   parameter int RAM_AW     = 16,
   parameter int WORD_COUNT = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_we,
   output logic [RAM_AW-1:0] word_addr,
   output logic              at_last
);
   localparam logic [RAM_AW-1:0] LAST_ADDR = RAM_AW'(WORD_COUNT - 1);

   logic [RAM_AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_q <= '0;
      else if (word_we) addr_q <= addr_q + RAM_AW'(1);
   end

   assign word_addr = addr_q;
   assign at_last   = (addr_q == LAST_ADDR);

   assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
      word_we |-> (32'(addr_q) < WORD_COUNT));
endmodule

// File: rtl/boot_word_loader.sv
module boot_word_loader #(
   parameter int                EXT_AW         = 16,
   parameter int                RAM_AW         = 16,
   parameter int                BYTES_PER_WORD = 3,
   parameter int                WAIT_CYCLES    = 2,
   parameter int                WORD_COUNT     = 1000,
   parameter logic [EXT_AW-1:0] SRC_BASE       = 16'h8000,
   localparam int               BYTE_W         = 8,
   localparam int               WORD_W         = BYTE_W * BYTES_PER_WORD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              ext_rd,
   output logic [EXT_AW-1:0] ext_addr,
   input  logic [BYTE_W-1:0] ext_data,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [WORD_W-1:0] ram_data,
   output logic              busy,
   output logic              cpu_run
);
   import boot_ld_pkg::*;

   generate
      if (WORD_COUNT < 1 || WORD_COUNT > (2 ** RAM_AW)) begin : g_bad_count
         $error("WORD_COUNT must lie in 1 .. 2**RAM_AW");
      end
      if (BYTES_PER_WORD < 1) begin : g_bad_bpw
         $error("BYTES_PER_WORD must be at least 1");
      end
      if (WAIT_CYCLES < 0) begin : g_bad_wait
         $error("WAIT_CYCLES must not be negative");
      end
      if (longint'(SRC_BASE) + longint'(WORD_COUNT) * BYTES_PER_WORD > (longint'(1) << EXT_AW)) begin : g_bad_span
         $error("image does not fit above SRC_BASE");
      end
   endgenerate

   ld_state_e state_q, state_d;

   logic              fetch_en;
   logic              byte_valid;
   logic [BYTE_W-1:0] byte_data;
   logic              last_byte;
   logic              word_valid;
   logic              at_last;

   assign fetch_en = (state_q == LD_COPY);

   ld_byte_fetch #(
      .EXT_AW      (EXT_AW),
      .BYTE_W      (BYTE_W),
      .WAIT_CYCLES (WAIT_CYCLES),
      .SRC_BASE    (SRC_BASE)
   ) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (fetch_en),
      .ext_data   (ext_data),
      .ext_rd     (ext_rd),
      .ext_addr   (ext_addr),
      .byte_valid (byte_valid),
      .byte_data  (byte_data)
   );

   ld_word_pack #(
      .BYTE_W         (BYTE_W),
      .BYTES_PER_WORD (BYTES_PER_WORD)
   ) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .last_byte  (last_byte),
      .word_valid (word_valid),
      .word_data  (ram_data)
   );

   ld_word_count #(
      .RAM_AW     (RAM_AW),
      .WORD_COUNT (WORD_COUNT)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_we   (word_valid),
      .word_addr (ram_addr),
      .at_last   (at_last)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LD_IDLE:  if (start)                state_d = LD_COPY;
         LD_COPY:  if (last_byte && at_last) state_d = LD_FLUSH;
         LD_FLUSH:                           state_d = LD_RUN;
         LD_RUN:                             state_d = LD_RUN;
         default:                            state_d = LD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LD_IDLE;
      else        state_q <= state_d;
   end

   assign ram_we  = word_valid;
   assign busy    = (state_q == LD_COPY) || (state_q == LD_FLUSH);
   assign cpu_run = (state_q == LD_RUN);

   assert_run_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_run |=> cpu_run);

   assert_run_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_run |-> (!ext_rd && !ram_we));

   assert_ram_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> (ram_addr == $past(ram_addr) + RAM_AW'(1)));

   assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cpu_run && start) |=> busy);
endmodule

// File: tb/test_boot_word_loader.sv
module test_boot_word_loader;
   localparam int          WAITC = 2;
   localparam int          NWORD = 1000;
   localparam logic [15:0] BASE  = 16'h8000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        ext_rd;
   logic [15:0] ext_addr;
   logic [7:0]  ext_data;
   logic        ram_we;
   logic [15:0] ram_addr;
   logic [23:0] ram_data;
   logic        busy;
   logic        cpu_run;

   always #2.5 clk = ~clk;

   boot_word_loader #(
      .EXT_AW(16), .RAM_AW(16), .BYTES_PER_WORD(3),
      .WAIT_CYCLES(WAITC), .WORD_COUNT(NWORD), .SRC_BASE(BASE)
   ) i_boot_word_loader (
      .clk(clk), .rst_n(rst_n), .start(start),
      .ext_rd(ext_rd), .ext_addr(ext_addr), .ext_data(ext_data),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_data(ram_data),
      .busy(busy), .cpu_run(cpu_run)
   );

   int checks = 0;
   int fails  = 0;
   logic [7:0] salt = 8'h00;

   task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] rom_byte(input logic [15:0] a);
      logic [15:0] m;
      m = a * 16'd37;
      return m[7:0] ^ a[12:5] ^ salt;
   endfunction

   function automatic logic [23:0] exp_word(input int k);
      logic [15:0] a;
      a = BASE + 16'(3 * k);
      return {rom_byte(a + 16'd2), rom_byte(a + 16'd1), rom_byte(a)};
   endfunction

   // slow memory model: byte is valid only in the cycle after WAITC held cycles
   logic        prev_rd = 1'b0;
   logic [15:0] prev_a  = 16'h0;
   int          run_r   = 0;
   int          cur;
   always_comb cur = (ext_rd && prev_rd && ext_addr == prev_a) ? run_r + 1 : 0;
   always @(posedge clk) begin
      prev_rd <= ext_rd;
      prev_a  <= ext_addr;
      run_r   <= cur;
   end
   assign ext_data = (ext_rd && cur == WAITC) ? rom_byte(ext_addr) : 8'hEE;

   // monitor
   logic        mon_on = 1'b0;
   int          cyc = 0;
   int          words_seen = 0;
   int          byte_idx = 0;
   int          hold = 0;
   int          last_we_cyc = 0;
   logic        was_rd = 1'b0;
   logic        was_we = 1'b0;
   logic        run_seen = 1'b0;
   logic [15:0] cur_a = 16'h0;

   always @(negedge clk) begin
      if (mon_on) begin
         cyc++;
         if (ram_we) begin
            chk(!was_we, "R7 strobe on adjacent cycles", 1, 0);
            chk(ram_addr == 16'(words_seen), "R6 ram address", ram_addr, words_seen);
            chk(ram_data == exp_word(words_seen), "R5 word packing", ram_data, exp_word(words_seen));
            words_seen++;
            last_we_cyc = cyc;
         end
         was_we = ram_we;
         if (ext_rd) begin
            if (was_rd && ext_addr == cur_a) begin
               hold++;
            end else begin
               if (was_rd) chk(hold == WAITC + 1, "R3 read hold length", hold, WAITC + 1);
               chk(ext_addr == BASE + 16'(byte_idx), "R4 byte address", ext_addr, BASE + 16'(byte_idx));
               byte_idx++;
               cur_a = ext_addr;
               hold  = 1;
            end
         end else if (was_rd) begin
            chk(hold == WAITC + 1, "R3 read hold length", hold, WAITC + 1);
         end
         was_rd = ext_rd;
         if (cpu_run && !run_seen) begin
            run_seen = 1'b1;
            chk(cyc == last_we_cyc + 1, "R8 run follows last write", cyc, last_we_cyc + 1);
         end
      end
   end

   logic finished = 1'b0;

   task automatic finish_up();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         finish_up();
      end
   end

   initial begin
      int seed_dummy;
      int gap;
      seed_dummy = $urandom(32'h1234_5A5A);
      salt = 8'($urandom);
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(!ext_rd && !ram_we && !busy && !cpu_run, "R1 idle outputs", {ext_rd, ram_we, busy, cpu_run}, 0);
      chk(ext_addr == BASE, "R1 ext_addr", ext_addr, BASE);
      chk(ram_addr == 16'h0, "R1 ram_addr", ram_addr, 0);
      @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;
      gap = 3 + int'($urandom_range(0, 20));
      repeat (gap) @(negedge clk);
      // R2 nothing moves without start
      chk(!ext_rd && !busy && !ram_we, "R2 idle without start", {ext_rd, busy}, 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      chk(ext_rd == 1'b1 && ext_addr == BASE, "R4 first read at base", ext_addr, BASE);
      // stray start in mid copy (R2: ignored)
      gap = 200 + int'($urandom_range(0, 3000));
      repeat (gap) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && !cpu_run, "R2 start during copy ignored", busy, 1);
      wait (run_seen);
      @(negedge clk);
      chk(words_seen == NWORD, "R9 word count", words_seen, NWORD);
      chk(byte_idx == 3 * NWORD, "R4 bytes read", byte_idx, 3 * NWORD);
      chk(cpu_run && !busy, "R8 released", {cpu_run, busy}, 2);
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      chk(words_seen == NWORD, "R2 start after done ignored (writes)", words_seen, NWORD);
      chk(byte_idx == 3 * NWORD, "R2 start after done ignored (reads)", byte_idx, 3 * NWORD);
      chk(cpu_run && !ext_rd && !ram_we, "R8 run sticky and quiet", {cpu_run, ext_rd, ram_we}, 4);
      finished = 1'b1;
      finish_up();
   end
endmodule